// File: doc/BRIEF.md
# Shared Result Bus Arbiter

This block shares one result bus among eleven producer units of an out-of-order floating-point unit. The producers are three adder stations, two multiply/divide stations and six load buffers. A producer with a finished result raises its request and presents its result. The arbiter picks one requester per cycle in round-robin order and returns a registered grant. In the next cycle it drives the granted producer's tag and result onto the bus. Every cycle, each consumer compares the bus tag with the tag it is waiting for, so one broadcast can satisfy many consumers at once.

The result reaches the bus two cycles after the cycle in which the request was first sampled. The grant falls in the cycle between, so the bus is reserved ahead of use. Tag 0 is never given to a unit, and the bus shows tag 0 whenever it carries no result.

Producer protocol: a producer keeps its request and result steady until its grant is seen, and through the grant cycle itself. It lowers the request, or presents its next result, in the cycle after the grant. The producer counts are parameters. The defaults are NUM_ADD=3, NUM_MUL=2, NUM_LOAD=6 and DATA_W=32.

Top module: `bcast_arbiter`

## Requirements
- R1: While reset is asserted, and afterwards until the first grant, grant_o, bus_valid_o, bus_tag_o and bus_value_o are all zero.
- R2: A request sampled at a rising edge, when the requester wins arbitration, shows up as its grant_o bit in the cycle that follows that edge.
- R3: One cycle after a grant, bus_valid_o is 1. bus_tag_o then carries the granted producer's tag, and bus_value_o carries the value that producer presented during its grant cycle.
- R4: At most one grant_o bit is high in any cycle. bus_valid_o is high exactly in the cycles that directly follow a cycle with a grant.
- R5: Arbitration is round-robin. The search starts at the index just after the last winner and wraps from index N-1 to 0. After reset, index 0 has the highest priority.
- R6: When bus_valid_o is low, bus_tag_o is 0 and bus_value_o is 0.
- R7: A producer is not granted in two consecutive cycles. The producer currently holding a grant is left out of that cycle's arbitration.
- R8: A producer at index i uses tag i+1. Adder stations are indices 0..2 (tags 1..3), multiply/divide stations are indices 3..4 (tags 4..5), and load buffers are indices 5..10 (tags 6..11). The data bus packs producer i at bits [i*DATA_W +: DATA_W].
- R9: A producer that holds its request is granted within N+1 cycles. Continuous requests from every producer starve none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | N (11) | Bus request, one bit per producer |
| data_i | input | N*DATA_W (352) | Result of each producer, packed by index |
| grant_o | output | N (11) | Registered one-hot grant |
| bus_valid_o | output | 1 | Bus carries a result this cycle |
| bus_tag_o | output | TAG_W (4) | Tag of the broadcasting producer, 0 when idle |
| bus_value_o | output | DATA_W (32) | Broadcast result, 0 when idle |

## Verification
A request sampled at rising edge k produces a grant in the cycle after edge k and a bus broadcast in the cycle after edge k+1. Both results are due a fixed number of register stages after the request, never in the same cycle. The bench steps its reference model on each rising edge and drives and compares only at falling edges, so both sides are compared in the cycle where each register has just updated. Directed checks count falling edges from the cycle the request was driven: the grant is expected at the first edge and the bus at the second.

// File: rtl/bcast_pkg.sv
package bcast_pkg;

   // tag value that names no producer
   localparam int unsigned IDLE_TAG = 0;

   // producer index to broadcast tag
   function automatic int unsigned tag_of(input int unsigned idx);
      return idx + 1;
   endfunction

   // width needed to hold values 0..n
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/bcast_rr_pick.sv
module bcast_rr_pick #(
   parameter int unsigned N = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   output logic [N-1:0] grant_q
);
   localparam int unsigned PTR_W = (N > 1) ? $clog2(N) : 1;

   logic [PTR_W-1:0] last_q;
   logic [N-1:0]     elig;
   logic [N-1:0]     win;
   logic [PTR_W-1:0] win_idx;
   logic             hit;

   // the holder of the current grant sits out this round
   assign elig = req_i & ~grant_q;

   always_comb begin
      int unsigned cand;
      win     = '0;
      win_idx = last_q;
      hit     = 1'b0;
      cand    = 0;
      for (int unsigned k = 1; k <= N; k++) begin
         cand = (int'(last_q) + k) % N;
         if (!hit && elig[cand]) begin
            hit        = 1'b1;
            win[cand]  = 1'b1;
            win_idx    = PTR_W'(cand);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         last_q  <= PTR_W'(N - 1);
      end else begin
         grant_q <= win;
         if (hit) last_q <= win_idx;
      end
   end

endmodule

// File: rtl/bcast_bus_drv.sv
module bcast_bus_drv #(
   parameter int unsigned N               = 11,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned TAG_W           = 4,
   parameter bit          HOLD_IDLE_VALUE = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        grant_i,
   input  logic [N*DATA_W-1:0] data_i,
   output logic                valid_q,
   output logic [TAG_W-1:0]    tag_q,
   output logic [DATA_W-1:0]   value_q
);
   logic [DATA_W-1:0] sel_val;
   logic [TAG_W-1:0]  sel_tag;
   logic              any_grant;

   assign any_grant = |grant_i;

   always_comb begin
      sel_val = '0;
      sel_tag = TAG_W'(bcast_pkg::IDLE_TAG);
      for (int unsigned i = 0; i < N; i++) begin
         sel_val = sel_val | (data_i[i*DATA_W +: DATA_W] & {DATA_W{grant_i[i]}});
         if (grant_i[i]) sel_tag = sel_tag | TAG_W'(bcast_pkg::tag_of(i));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         tag_q   <= '0;
      end else begin
         valid_q <= any_grant;
         tag_q   <= sel_tag;
      end
   end

   generate
      if (HOLD_IDLE_VALUE) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         value_q <= '0;
            else if (any_grant) value_q <= sel_val;
         end
      end else begin : g_zero
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) value_q <= '0;
            else        value_q <= sel_val;
         end
      end
   endgenerate

endmodule

// File: rtl/bcast_arbiter.sv
module bcast_arbiter #(
   parameter int unsigned NUM_ADD         = 3,
   parameter int unsigned NUM_MUL         = 2,
   parameter int unsigned NUM_LOAD        = 6,
   parameter int unsigned DATA_W          = 32,
   parameter bit          HOLD_IDLE_VALUE = 1'b0,
   localparam int unsigned N              = NUM_ADD + NUM_MUL + NUM_LOAD,
   localparam int unsigned TAG_W          = bcast_pkg::bits_for(N)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N-1:0]        req_i,
   input  logic [N*DATA_W-1:0] data_i,
   output logic [N-1:0]        grant_o,
   output logic                bus_valid_o,
   output logic [TAG_W-1:0]    bus_tag_o,
   output logic [DATA_W-1:0]   bus_value_o
);
   generate
      if (NUM_ADD < 1 || NUM_MUL < 1 || NUM_LOAD < 1) begin : g_bad_count
         $error("each producer class needs at least one unit");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
   endgenerate

   logic [N-1:0] grant_q;

   bcast_rr_pick #(.N(N)) u_pick (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req_i),
      .grant_q (grant_q)
   );

   bcast_bus_drv #(
      .N               (N),
      .DATA_W          (DATA_W),
      .TAG_W           (TAG_W),
      .HOLD_IDLE_VALUE (HOLD_IDLE_VALUE)
   ) u_drv (
      .clk     (clk),
      .rst_n   (rst_n),
      .grant_i (grant_q),
      .data_i  (data_i),
      .valid_q (bus_valid_o),
      .tag_q   (bus_tag_o),
      .value_q (bus_value_o)
   );

   assign grant_o = grant_q;

endmodule

module bcast_arbiter_chk #(
   parameter int unsigned N         = 11,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned TAG_W     = 4,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      req_i,
   input logic [N-1:0]      grant_o,
   input logic              bus_valid_o,
   input logic [TAG_W-1:0]  bus_tag_o,
   input logic [DATA_W-1:0] bus_value_o
);
   localparam int unsigned CW = bcast_pkg::bits_for(N + 2);

   logic [TAG_W-1:0] exp_tag;
   logic [CW-1:0]    wait_q [N];

   always_comb begin
      exp_tag = '0;
      for (int unsigned i = 0; i < N; i++)
         if (grant_o[i]) exp_tag = TAG_W'(i + 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int unsigned i = 0; i < N; i++) wait_q[i] <= '0;
      end else begin
         for (int unsigned i = 0; i < N; i++) begin
            if (!req_i[i] || grant_o[i])     wait_q[i] <= '0;
            else if (wait_q[i] < CW'(N + 2)) wait_q[i] <= wait_q[i] + 1'b1;
         end
      end
   end

   // R4
   single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R4
   valid_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |=> bus_valid_o);

   // R4
   quiet_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|grant_o) |=> !bus_valid_o);

   // R3
   tag_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |=> (bus_tag_o == $past(exp_tag)));

   // R6
   idle_tag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid_o |-> (bus_tag_o == '0));

   // R6
   idle_value_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid_o && ZERO_IDLE) |-> (bus_value_o == '0));

   // R7
   no_repeat_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|grant_o) |=> ((grant_o & $past(grant_o)) == '0));

   generate
      for (genvar g = 0; g < N; g++) begin : g_wait
         // R9
         bounded_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wait_q[g] <= CW'(N + 1));
      end
   endgenerate

endmodule

bind bcast_arbiter bcast_arbiter_chk #(
   .N         (N),
   .DATA_W    (DATA_W),
   .TAG_W     (TAG_W),
   .ZERO_IDLE (!HOLD_IDLE_VALUE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .grant_o     (grant_o),
   .bus_valid_o (bus_valid_o),
   .bus_tag_o   (bus_tag_o),
   .bus_value_o (bus_value_o)
);

// File: tb/tb_bcast_arbiter.sv
module tb_bcast_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int NP         = 11;
   localparam int DW         = 32;
   localparam int TW         = 4;
   localparam int DEPTH      = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NP-1:0]    req = '0;
   logic [NP*DW-1:0] data = '0;
   logic [NP-1:0]    grant_o;
   logic             bus_valid_o;
   logic [TW-1:0]    bus_tag_o;
   logic [DW-1:0]    bus_value_o;

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   // producer result stores
   logic [DW-1:0] vals [NP][DEPTH];
   int            head [NP];
   int            tail [NP];
   bit            pop_pend [NP];

   // reference model state
   int            m_last;
   int            m_grant;
   int            m_pick;
   logic          m_valid;
   logic [TW-1:0] m_tag;
   logic [DW-1:0] m_value;

   bcast_arbiter dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_i       (req),
      .data_i      (data),
      .grant_o     (grant_o),
      .bus_valid_o (bus_valid_o),
      .bus_tag_o   (bus_tag_o),
      .bus_value_o (bus_value_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", rq, what, act, exp, cyc);
      end
   endtask

   task automatic push(input int p, input logic [DW-1:0] v);
      vals[p][tail[p] % DEPTH] = v;
      tail[p]++;
   endtask

   function automatic logic [NP-1:0] exp_grant_vec();
      logic [NP-1:0] g;
      g = '0;
      if (m_grant >= 0) g[m_grant] = 1'b1;
      return g;
   endfunction

   // behavioural model, stepped on the rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_last  = NP - 1;
         m_grant = -1;
         m_valid = 1'b0;
         m_tag   = '0;
         m_value = '0;
      end else begin
         if (m_grant >= 0) begin
            m_valid = 1'b1;
            m_tag   = TW'(m_grant + 1);
            m_value = data[m_grant*DW +: DW];
         end else begin
            m_valid = 1'b0;
            m_tag   = '0;
            m_value = '0;
         end
         m_pick = -1;
         for (int k = 1; k <= NP; k++) begin
            int c;
            c = (m_last + k) % NP;
            if (m_pick < 0 && req[c] && c != m_grant) m_pick = c;
         end
         m_grant = m_pick;
         if (m_pick >= 0) m_last = m_pick;
      end
   end

   // compare, then act as the producers, on the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 R5 R7", "grant", 64'(grant_o), 64'(exp_grant_vec()));
         chk("R4", "bus_valid", 64'(bus_valid_o), 64'(m_valid));
         chk("R3 R8", "bus_tag", 64'(bus_tag_o), 64'(m_tag));
         chk("R3 R6", "bus_value", 64'(bus_value_o), 64'(m_value));
      end
      for (int i = 0; i < NP; i++) begin
         if (pop_pend[i]) begin
            head[i]++;
            pop_pend[i] = 1'b0;
         end
         if (grant_o[i]) pop_pend[i] = 1'b1;
         req[i] = (head[i] != tail[i]);
         data[i*DW +: DW] = (head[i] != tail[i]) ? vals[i][head[i] % DEPTH] : '0;
      end
   end

   // watchdog
   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL R9 watchdog actual=%0d expected<=20000 cycles", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      for (int i = 0; i < NP; i++) begin
         head[i] = 0; tail[i] = 0; pop_pend[i] = 1'b0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state held in reset
      chk("R1", "grant in reset", 64'(grant_o), 64'd0);
      chk("R1", "valid in reset", 64'(bus_valid_o), 64'd0);
      chk("R1", "tag in reset", 64'(bus_tag_o), 64'd0);
      chk("R1", "value in reset", 64'(bus_value_o), 64'd0);
      rst_n = 1'b1;
      wait_idle(2);

      // R2 R3 R7: single add station 2 with two results
      push(2, 32'hCAFE_0001);
      push(2, 32'hCAFE_0002);
      @(negedge clk);                                  // request driven
      @(negedge clk);
      chk("R2", "first grant", 64'(grant_o), 64'(11'b000_0000_0100));
      @(negedge clk);
      chk("R7", "no back-to-back grant", 64'(grant_o), 64'd0);
      chk("R3", "first tag", 64'(bus_tag_o), 64'd3);
      chk("R3", "first value", 64'(bus_value_o), 64'hCAFE_0001);
      @(negedge clk);
      chk("R2", "second grant", 64'(grant_o), 64'(11'b000_0000_0100));
      @(negedge clk);
      chk("R3", "second value", 64'(bus_value_o), 64'hCAFE_0002);
      wait_idle(4);

      // R8: last load buffer carries tag 11
      push(10, 32'h0000_00A5);
      @(negedge clk);
      @(negedge clk);
      chk("R8", "load grant", 64'(grant_o), 64'(11'b100_0000_0000));
      @(negedge clk);
      chk("R8", "load tag", 64'(bus_tag_o), 64'd11);
      chk("R8", "load value", 64'(bus_value_o), 64'h0000_00A5);
      wait_idle(4);
      @(negedge clk);
      // R6: idle bus
      chk("R6", "idle tag", 64'(bus_tag_o), 64'd0);
      chk("R6", "idle value", 64'(bus_value_o), 64'd0);
      @(posedge clk); #1;

      // R5: all producers at once, last winner was index 10
      for (int i = 0; i < NP; i++) push(i, DW'(32'h1000 + i));
      @(negedge clk);
      @(negedge clk);
      for (int k = 0; k < NP; k++) begin
         @(negedge clk);
         chk("R5", "rotation tag", 64'(bus_tag_o), 64'(k + 1));
      end
      wait_idle(4);

      // R9: continuous requests from all producers
      for (int r = 0; r < 4; r++)
         for (int i = 0; i < NP; i++) push(i, DW'(32'h2000 + r*16 + i));
      wait_idle(110);
      for (int i = 0; i < NP; i++)
         chk("R9", "producer drained", 64'(tail[i] - head[i]), 64'd0);

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule